// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block turns a set of already-digitized supervisory flags into one active-low system reset. A low supply flag, a low sense flag or a low manual request each force the reset. The reset is then held for a fixed number of tick-clock cycles after the last of these causes goes away. A built-in watchdog must be kicked by a transition, in either direction, on its input. If no transition arrives within the timeout window, the watchdog forces a reset pulse of full length and raises a one-cycle status flag that tells this cause apart from the others.

All flags are asynchronous to the tick clock and pass through a two-stage synchronizer first. The release delay and the watchdog timeout are parameters counted in tick cycles. Their defaults suit a 1 kHz tick (130 and 1100), and a simulation can use much smaller values.

Top module: `sup_reset_ctrl`

## Requirements
- R1: A low `supply_ok` drives `sys_rst_n` low two clock edges after the edge that first samples it.
- R2: A low `sense_ok` drives `sys_rst_n` low with the same two-edge latency as R1.
- R3: While `mrst_n` is low, `sys_rst_n` stays low. It stays low for the full release delay after `mrst_n` returns high.
- R4: Once every cause has cleared, `sys_rst_n` rises exactly DELAY_CYC+1 edges after the edge that first samples the cleared inputs. This holds for any cause width, including a single cycle.
- R5: A cause that returns while the release delay is running keeps `sys_rst_n` low. The delay then counts again in full from the moment that cause clears.
- R6: Any change of `wdog_in`, whether rising or falling, clears the watchdog count. Changes spaced up to TIMEOUT_CYC cycles apart never cause a reset or a status pulse.
- R7: When `wdog_in` has not changed for TIMEOUT_CYC cycles while the block is out of reset, `wdog_expired` goes high for exactly one cycle. This happens TIMEOUT_CYC+2 edges after the edge that sampled the last change. `sys_rst_n` goes low one edge later and stays low for DELAY_CYC cycles.
- R8: The watchdog count is held at zero while `sys_rst_n` is low, so a reset of any length raises no `wdog_expired` pulse.
- R9: While `rst_n` is low, `sys_rst_n` is low and `wdog_expired` is low. After `rst_n` rises with all flags high, `sys_rst_n` follows the R4 timing.
- R10: The release counter never counts past DELAY_CYC, and the watchdog counter never counts past TIMEOUT_CYC-1. Both counters hold at their limit instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running tick clock |
| rst_n | input | 1 | Synchronous active-low reset of the block's own logic |
| supply_ok | input | 1 | High when the supply is above its threshold (asynchronous) |
| sense_ok | input | 1 | High when the secondary sensed voltage is above its threshold (asynchronous) |
| mrst_n | input | 1 | Active-low manual reset request (asynchronous) |
| wdog_in | input | 1 | Watchdog kick; each change of level restarts the timeout |
| sys_rst_n | output | 1 | Active-low system reset |
| wdog_expired | output | 1 | One-cycle pulse when a watchdog timeout starts a reset |

## Verification
The bench builds the block with DELAY_CYC = 6 and TIMEOUT_CYC = 10. At these values every path fits in a few dozen cycles, so the bench can sweep exhaustively. It covers every cause with widths 1 to 5, every re-trigger gap that falls inside the release delay, and every kick spacing from 1 up to the timeout limit. At the limit, kicks spaced exactly TIMEOUT_CYC apart land on the last cycle before expiry. The bench also measures a real expiry to the cycle: the pulse, the assertion and the release.

// File: rtl/sup_pkg.sv
package sup_pkg;
    // Bundle of the asynchronous supervisory inputs, synchronized as one vector.
    typedef struct packed {
        logic supply_ok;
        logic sense_ok;
        logic mrst_n;
        logic wdog;
    } sup_in_t;

    localparam int unsigned SUP_IN_W = $bits(sup_in_t);
endpackage

// File: rtl/sup_sync.sv
// sup_sync: two-stage synchronizer for a vector of independent asynchronous bits.
// Assumes each bit is a level that may change at any time; no bus coherence is implied.
// Reset value of every stage is 0, which reads as "cause present" for the flags.
module sup_sync #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic stage1;
        logic stage2;
        // Two flops in series per bit to settle metastability.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1 <= 1'b0;
                stage2 <= 1'b0;
            end else begin
                stage1 <= d[b];
                stage2 <= stage1;
            end
        end
        assign q[b] = stage2;
    end
endmodule

// File: rtl/sup_stretch.sv
// sup_stretch: holds the reset low while a cause is present and for DELAY_CYC
// cycles after it clears. Assumes DELAY_CYC >= 1 and a synchronous cause input.
module sup_stretch #(
    parameter int unsigned DELAY_CYC = 130
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cause,
    output logic rst_out_n
);
    localparam int unsigned CW = $clog2(DELAY_CYC + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(DELAY_CYC);

    logic [CW-1:0] cnt;

    // Count cycles since the last cause, restarting on each cause, holding at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cause) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign rst_out_n = (cnt == CNT_MAX);

    a_r10_delay_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_MAX);

    a_r4_release_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> $past(!cause));
endmodule

// File: rtl/sup_wdog.sv
// sup_wdog: watchdog timer kicked by any change of a synchronized input.
// Assumes TIMEOUT_CYC >= 3. The count is held cleared while 'released' is low
// and a one-cycle 'expired' pulse is issued on timeout.
module sup_wdog #(
    parameter int unsigned TIMEOUT_CYC = 1100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wdi_s,
    input  logic released,
    output logic expired
);
    localparam int unsigned WW = $clog2(TIMEOUT_CYC);
    localparam logic [WW-1:0] W_LAST = WW'(TIMEOUT_CYC - 1);

    logic          wdi_prev;
    logic          kick;
    logic [WW-1:0] wcnt;

    // Keep the previous synchronized sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wdi_prev <= 1'b0;
        else        wdi_prev <= wdi_s;
    end

    assign kick = wdi_s ^ wdi_prev;

    // Idle counter: cleared by a kick or by reset, otherwise counts and holds at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0;
        end else if (!released || kick) begin
            wcnt <= '0;
        end else if (wcnt != W_LAST) begin
            wcnt <= wcnt + 1'b1;
        end
    end

    // Expiry pulse: one cycle when the idle count reaches its limit with no kick.
    always_ff @(posedge clk) begin
        if (!rst_n) expired <= 1'b0;
        else        expired <= released && !kick && (wcnt == W_LAST) && !expired;
    end

    a_r8_clear_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !released |=> (wcnt == '0));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !expired);

    a_r7_only_when_released: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(released));

    a_r10_wdog_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt <= W_LAST);
endmodule

// File: rtl/sup_reset_ctrl.sv
// sup_reset_ctrl: supervisory reset generator. It ORs the supply, sense, manual and
// watchdog causes into one active-low reset, which is stretched by DELAY_CYC ticks.
// Assumes a free-running tick clock and asynchronous flag inputs.
module sup_reset_ctrl
    import sup_pkg::*;
#(
    parameter int unsigned DELAY_CYC   = 130,
    parameter int unsigned TIMEOUT_CYC = 1100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic sense_ok,
    input  logic mrst_n,
    input  logic wdog_in,
    output logic sys_rst_n,
    output logic wdog_expired
);
    sup_in_t raw_in;
    sup_in_t syn_in;
    logic    cause;

    assign raw_in = '{supply_ok: supply_ok, sense_ok: sense_ok,
                      mrst_n: mrst_n, wdog: wdog_in};

    sup_sync #(.WIDTH(SUP_IN_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    // Any single cause holds the system in reset.
    assign cause = !syn_in.supply_ok || !syn_in.sense_ok || !syn_in.mrst_n || wdog_expired;

    sup_stretch #(.DELAY_CYC(DELAY_CYC)) u_stretch (
        .clk       (clk),
        .rst_n     (rst_n),
        .cause     (cause),
        .rst_out_n (sys_rst_n)
    );

    sup_wdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .wdi_s    (syn_in.wdog),
        .released (sys_rst_n),
        .expired  (wdog_expired)
    );

    // R1, R2, R3: a present cause shows on the output one edge later.
    a_r1_cause_asserts: assert property (@(posedge clk) disable iff (!rst_n)
        cause |=> !sys_rst_n);

    a_r7_expiry_resets: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_expired |=> !sys_rst_n);

    a_r3_manual_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !syn_in.mrst_n |=> !sys_rst_n);
endmodule

// File: tb/test_sup_reset_ctrl.sv
module test_sup_reset_ctrl;
    localparam int D = 6;
    localparam int T = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1;
    logic sense_ok = 1'b1;
    logic mrst_n = 1'b1;
    logic wdi = 1'b0;
    logic sys_rst_n;
    logic wdog_expired;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sup_reset_ctrl #(.DELAY_CYC(D), .TIMEOUT_CYC(T)) i_sup_reset_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_ok    (supply_ok),
        .sense_ok     (sense_ok),
        .mrst_n       (mrst_n),
        .wdog_in      (wdi),
        .sys_rst_n    (sys_rst_n),
        .wdog_expired (wdog_expired)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // sel 0 supply, 1 sense, 2 manual, 3 logic reset, other: none
    task automatic drive(input int sel, input logic v);
        supply_ok = (sel == 0) ? v : 1'b1;
        sense_ok  = (sel == 1) ? v : 1'b1;
        mrst_n    = (sel == 2) ? v : 1'b1;
        rst_n     = (sel == 3) ? v : 1'b1;
    endtask

    // Cause low at steps [0,w1) and [w1+gap, w1+gap+w2); optional kicks every wd_p before wd_stop.
    // Results are 1-based sample indices (0 = never seen).
    task automatic run(input int sel, input int w1, input int gap, input int w2,
                       input int wd_p, input int wd_stop, input int kmax,
                       output int lo, output int hi, output int pn, output int pulses);
        lo = 0; hi = 0; pn = 0; pulses = 0;
        for (int k = 0; k < kmax; k++) begin
            @(negedge clk);
            drive(sel, !((k < w1) || (k >= w1 + gap && k < w1 + gap + w2)));
            if (wd_p > 0 && k < wd_stop && (k % wd_p) == 0) wdi = ~wdi;
            @(posedge clk); #1;
            if (!sys_rst_n && lo == 0) lo = k + 1;
            if (sys_rst_n && lo != 0 && hi == 0) hi = k + 1;
            if (wdog_expired) begin
                pulses++;
                if (pn == 0) pn = k + 1;
            end
            if (hi != 0) break;
        end
    endtask

    initial begin
        int lo, hi, pn, pulses;
        // R9: hold logic reset
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset output", int'(sys_rst_n), 0);
        check("R9 no status in reset", int'(wdog_expired), 0);
        run(3, 2, 0, 0, 0, 0, 60, lo, hi, pn, pulses);
        check("R9 release after logic reset", hi, 2 + D + 2);

        // R1 R2 R3 R4: each cause, widths 1..5
        for (int sel = 0; sel < 3; sel++) begin
            for (int w = 1; w <= 5; w++) begin
                run(sel, w, 0, 0, 0, 0, 60, lo, hi, pn, pulses);
                check(sel == 0 ? "R1 assert latency" : sel == 1 ? "R2 assert latency"
                                                     : "R3 assert latency", lo, 3);
                check(sel == 2 ? "R3 manual hold" : "R4 release delay", hi, w + D + 2);
            end
        end

        // R5: re-trigger at every gap inside the delay
        for (int gap = 1; gap < D; gap++) begin
            run(gap % 3, 2, gap, 1, 0, 0, 60, lo, hi, pn, pulses);
            check("R5 restart on returning cause", hi, 2 + gap + 1 + D + 2);
        end

        // R8: long manual reset, no kicks, no expiry pulse
        run(2, 3 * T, 0, 0, 0, 0, 100, lo, hi, pn, pulses);
        check("R8 no pulse during reset", pulses, 0);
        check("R8 release after long reset", hi, 3 * T + D + 2);

        // R6: kicks at every spacing up to T keep the system out of reset
        for (int p = T; p >= 1; p--) begin
            run(-1, 0, 0, 0, p, 1000, 3 * T, lo, hi, pn, pulses);
            check("R6 kicked no reset", lo, 0);
            check("R6 kicked no pulse", pulses, 0);
        end

        // R7: kicks at steps 0,2,4 then silence
        run(-1, 0, 0, 0, 2, 5, 60, lo, hi, pn, pulses);
        check("R7 pulse time", pn, 4 + T + 3);
        check("R7 single pulse", pulses, 1);
        check("R7 reset time", lo, 4 + T + 4);
        check("R7 reset length", hi, 4 + T + D + 4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0 (run hung)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule